// File: doc/BRIEF.md
# NAND Flash Controller Command Launch Register Block

This block is the software-visible register front end of a raw NAND flash controller. A 32-bit register bus writes the command bytes, the cycle-code bitmask, the column and row addresses, the transfer size and the controller configuration. The block holds these values and presents them as control fields to a pin sequencer, an ECC engine and a data buffer. Those three units are outside this block.

Setting the start bit in the main command register hands one operation to a stub sequencer. The stub stays busy for a programmable number of cycles and then raises the idle and done flags in the interrupt status register. Software clears each flag by writing a one to its clear bit. An interrupt output follows the idle flag when the idle enable is set.

The row address register also carries a one-hot chip-select nibble and a ready/busy-select nibble, which the block drives directly onto output pins.

Top module: `nfcr_ctrl_regs`

## Requirements
- R1: After reset, every mapped register reads zero, and `seq_busy`, `seq_launch` and `irq` are 0.
- R2: Registers keep only their defined bits, and undefined bits read zero:
  - main command (offset 0x00): mask 0xFFFFFF06, with first command byte 31:24, cycle code 23:8 and buffer number 2:1;
  - auxiliary command (0x04): second command byte 31:24;
  - column (0x08): bits 15:0;
  - transfer size (0x10): bits 12:0;
  - configuration (0x14): mask 0x7FFF00FF.
- R3: A write to offset 0x00 with bit 0 set while not busy produces a one-cycle `seq_launch` in the cycle after the write. `seq_busy` is 1 from the following cycle. Bit 0 reads back 0 once the launch has happened.
- R4: After a launch with `seq_delay` = D, `seq_busy` stays high for exactly D+1 cycles. When it falls, the status register (0x18) shows idle in bit 29 and done in bit 30.
- R5: A start written while `seq_busy` is high is ignored: there is no `seq_launch`, and the running operation's busy length does not change.
- R6: In the status register, writing 1 to bit 17 clears idle and writing 1 to bit 18 clears done. Writing 0 to those bits leaves the flags as they are. Bit 20 is a read/write idle-interrupt enable.
- R7: `irq` is 1 exactly when the idle flag is set and the enable bit 20 is 1.
- R8: The row register (0x0C) reads back all 32 bits:
  - bits 23:0 drive `seq_row`;
  - bits 27:24 drive `chip_sel`;
  - bits 31:28 drive `rb_sel`.
- R9: `cfg_ecc_mode` equals configuration bits 19:17. `cfg_ecc_bytes` is 0 for mode 0, 45 for mode 6, 60 for mode 7, and 0 for every other mode.
- R10: `cfg_ecc_stat_addr` equals configuration bits 30:22 multiplied by 8.
- R11: A read of an unmapped offset (0x1C and above, or any offset that is not word aligned) returns zero. A write to an unmapped offset changes no register.
- R12: The command outputs mirror the registers:
  - `seq_cmd_first`, `seq_cycle_code` and `seq_buf_id` come from the main command register;
  - `seq_cmd_second` comes from auxiliary bits 31:24;
  - `seq_col` and `seq_xfer_size` come from their own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| seq_delay | input | DLY_W | Stub sequencer busy length minus one |
| seq_launch | output | 1 | One-cycle operation launch |
| seq_busy | output | 1 | Operation in progress |
| seq_cmd_first | output | 8 | First command byte |
| seq_cmd_second | output | 8 | Second command byte |
| seq_cycle_code | output | 16 | Cycle-code bitmask |
| seq_buf_id | output | 2 | Buffer number |
| seq_col | output | 16 | Column address |
| seq_row | output | 24 | Row address |
| seq_xfer_size | output | SIZE_W | Transfer size in bytes |
| chip_sel | output | 4 | One-hot chip select |
| rb_sel | output | 4 | Ready/busy line select |
| cfg_word | output | 32 | Configuration register contents |
| cfg_ecc_mode | output | 3 | ECC mode |
| cfg_ecc_bytes | output | 7 | ECC parity bytes for the mode |
| cfg_ecc_stat_addr | output | 12 | Byte address of the ECC status word |
| irq | output | 1 | Idle interrupt |

## Verification
The assertions check, on every cycle:
- a launch is always followed by busy;
- no launch is ever granted while busy;
- the idle and done flags are set whenever busy falls;
- a write-one clear of idle takes effect unless a completion arrives in the same cycle;
- `irq` can only rise while the enable is set.

Only the bench scenarios can show:
- the register masks and read-back values;
- the exact busy length for a given delay, including zero;
- that an overlapping start leaves the busy length unchanged;
- that unmapped writes leave all registers untouched;
- the ECC byte count and status-address mapping.

// File: rtl/nfcr_pkg.sv
package nfcr_pkg;
  localparam int NREG = 7;

  // Register slot indices; the byte offset of a slot is 4 * index
  localparam int IDX_CMD_MAIN = 0;
  localparam int IDX_CMD_AUX  = 1;
  localparam int IDX_COL      = 2;
  localparam int IDX_ROW      = 3;
  localparam int IDX_SIZE     = 4;
  localparam int IDX_CFG      = 5;
  localparam int IDX_STAT     = 6;

  // Writable bits of each register
  localparam logic [31:0] CMD_MAIN_MASK = 32'hFFFF_FF06;
  localparam logic [31:0] CMD_AUX_MASK  = 32'hFF00_0000;
  localparam logic [31:0] CFG_MASK      = 32'h7FFF_00FF;

  // Bit positions in the status register and the main command register
  localparam int START_POS    = 0;
  localparam int CLR_IDLE_POS = 17;
  localparam int CLR_DONE_POS = 18;
  localparam int IEN_POS      = 20;
  localparam int IDLE_POS     = 29;
  localparam int DONE_POS     = 30;

  typedef enum logic [2:0] {
    ECC_OFF = 3'd0,
    ECC_45  = 3'd6,
    ECC_60  = 3'd7
  } ecc_mode_e;

  function automatic logic [6:0] ecc_parity_bytes(input logic [2:0] mode);
    case (mode)
      ECC_45:  return 7'd45;
      ECC_60:  return 7'd60;
      default: return 7'd0;
    endcase
  endfunction

  function automatic logic [11:0] ecc_stat_byte_addr(input logic [8:0] dword_idx);
    return {dword_idx, 3'b000};
  endfunction
endpackage

// File: rtl/nfcr_decode.sv
module nfcr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  output logic [nfcr_pkg::NREG-1:0] rd_hit,
  output logic [nfcr_pkg::NREG-1:0] wr_hit
);
  for (genvar i = 0; i < nfcr_pkg::NREG; i++) begin : g_slot
    assign rd_hit[i] = bus_sel && (bus_addr == ADDR_W'(4 * i));
    assign wr_hit[i] = rd_hit[i] && bus_wr;
  end
endmodule

// File: rtl/nfcr_launch.sv
module nfcr_launch #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [DLY_W-1:0] delay,
  output logic             accept,
  output logic             finish,
  output logic             busy
);
  logic [DLY_W-1:0] remain_q;

  assign accept = start_req && !busy;
  assign finish = busy && (remain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      remain_q <= delay;
    end else if (finish) begin
      busy     <= 1'b0;
    end else if (busy) begin
      remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/nfcr_status.sv
module nfcr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic clr_idle,
  input  logic clr_done,
  input  logic ien_wdata,
  input  logic accept,
  input  logic finish,
  output logic idle_q,
  output logic done_q,
  output logic ien_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      done_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (stat_wr) ien_q <= ien_wdata;
      // a completion takes priority over a clear written in the same cycle
      if (finish)                     idle_q <= 1'b1;
      else if (accept)                idle_q <= 1'b0;
      else if (stat_wr && clr_idle)   idle_q <= 1'b0;
      if (finish)                     done_q <= 1'b1;
      else if (accept)                done_q <= 1'b0;
      else if (stat_wr && clr_done)   done_q <= 1'b0;
    end
  end

  assign irq = idle_q && ien_q;
endmodule

// File: rtl/nfcr_ctrl_regs.sv
module nfcr_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 13,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [DLY_W-1:0]  seq_delay,
  output logic              seq_launch,
  output logic              seq_busy,
  output logic [7:0]        seq_cmd_first,
  output logic [7:0]        seq_cmd_second,
  output logic [15:0]       seq_cycle_code,
  output logic [1:0]        seq_buf_id,
  output logic [15:0]       seq_col,
  output logic [23:0]       seq_row,
  output logic [SIZE_W-1:0] seq_xfer_size,
  output logic [3:0]        chip_sel,
  output logic [3:0]        rb_sel,
  output logic [31:0]       cfg_word,
  output logic [2:0]        cfg_ecc_mode,
  output logic [6:0]        cfg_ecc_bytes,
  output logic [11:0]       cfg_ecc_stat_addr,
  output logic              irq
);
  import nfcr_pkg::*;

  logic [NREG-1:0]   rd_hit, wr_hit;
  logic [31:0]       cmd_main_q, cmd_aux_q, row_q, cfg_q;
  logic [15:0]       col_q;
  logic [SIZE_W-1:0] size_q;
  logic              start_q;
  logic              accept_ev, finish_ev;
  logic              idle_q, done_q, ien_q;
  logic              stat_wr;

  nfcr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_main_q <= '0;
      cmd_aux_q  <= '0;
      col_q      <= '0;
      row_q      <= '0;
      size_q     <= '0;
      cfg_q      <= '0;
      start_q    <= 1'b0;
    end else begin
      // start lives for one cycle: it is either accepted or dropped
      start_q <= wr_hit[IDX_CMD_MAIN] && bus_wdata[START_POS];
      if (wr_hit[IDX_CMD_MAIN]) cmd_main_q <= bus_wdata & CMD_MAIN_MASK;
      if (wr_hit[IDX_CMD_AUX])  cmd_aux_q  <= bus_wdata & CMD_AUX_MASK;
      if (wr_hit[IDX_COL])      col_q      <= bus_wdata[15:0];
      if (wr_hit[IDX_ROW])      row_q      <= bus_wdata;
      if (wr_hit[IDX_SIZE])     size_q     <= bus_wdata[SIZE_W-1:0];
      if (wr_hit[IDX_CFG])      cfg_q      <= bus_wdata & CFG_MASK;
    end
  end

  nfcr_launch #(.DLY_W(DLY_W)) u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_q),
    .delay    (seq_delay),
    .accept   (accept_ev),
    .finish   (finish_ev),
    .busy     (seq_busy)
  );

  assign stat_wr = wr_hit[IDX_STAT];

  nfcr_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_wr  (stat_wr),
    .clr_idle (bus_wdata[CLR_IDLE_POS]),
    .clr_done (bus_wdata[CLR_DONE_POS]),
    .ien_wdata(bus_wdata[IEN_POS]),
    .accept   (accept_ev),
    .finish   (finish_ev),
    .idle_q   (idle_q),
    .done_q   (done_q),
    .ien_q    (ien_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit[IDX_CMD_MAIN]) bus_rdata = cmd_main_q | {31'b0, start_q};
    if (rd_hit[IDX_CMD_AUX])  bus_rdata = cmd_aux_q;
    if (rd_hit[IDX_COL])      bus_rdata = {16'b0, col_q};
    if (rd_hit[IDX_ROW])      bus_rdata = row_q;
    if (rd_hit[IDX_SIZE])     bus_rdata = {{(32-SIZE_W){1'b0}}, size_q};
    if (rd_hit[IDX_CFG])      bus_rdata = cfg_q;
    if (rd_hit[IDX_STAT]) begin
      bus_rdata[DONE_POS] = done_q;
      bus_rdata[IDLE_POS] = idle_q;
      bus_rdata[IEN_POS]  = ien_q;
    end
  end

  assign seq_launch        = accept_ev;
  assign seq_cmd_first     = cmd_main_q[31:24];
  assign seq_cycle_code    = cmd_main_q[23:8];
  assign seq_buf_id        = cmd_main_q[2:1];
  assign seq_cmd_second    = cmd_aux_q[31:24];
  assign seq_col           = col_q;
  assign seq_row           = row_q[23:0];
  assign chip_sel          = row_q[27:24];
  assign rb_sel            = row_q[31:28];
  assign seq_xfer_size     = size_q;
  assign cfg_word          = cfg_q;
  assign cfg_ecc_mode      = cfg_q[19:17];
  assign cfg_ecc_bytes     = ecc_parity_bytes(cfg_q[19:17]);
  assign cfg_ecc_stat_addr = ecc_stat_byte_addr(cfg_q[30:22]);
endmodule

// File: rtl/nfcr_ctrl_regs_chk.sv
module nfcr_ctrl_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic seq_launch,
  input logic seq_busy,
  input logic finish_ev,
  input logic stat_wr,
  input logic clr_idle_bit,
  input logic idle_q,
  input logic done_q,
  input logic ien_q,
  input logic irq
);
  assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> seq_busy);

  assert_no_relaunch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !seq_launch);

  assert_flags_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> (idle_q && done_q));

  assert_w1c_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && clr_idle_bit && !finish_ev && !seq_launch) |=> !idle_q);

  assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ien_q);
endmodule

bind nfcr_ctrl_regs nfcr_ctrl_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seq_launch  (seq_launch),
  .seq_busy    (seq_busy),
  .finish_ev   (finish_ev),
  .stat_wr     (stat_wr),
  .clr_idle_bit(bus_wdata[17]),
  .idle_q      (idle_q),
  .done_q      (done_q),
  .ien_q       (ien_q),
  .irq         (irq)
);

// File: tb/nfcr_ctrl_regs_tb.sv
module nfcr_ctrl_regs_tb;
  localparam int ADDR_W = 8;
  localparam int SIZE_W = 13;
  localparam int DLY_W  = 8;
  localparam time CLK_PERIOD = 20ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [DLY_W-1:0]  seq_delay = '0;
  logic              seq_launch, seq_busy, irq;
  logic [7:0]        seq_cmd_first, seq_cmd_second;
  logic [15:0]       seq_cycle_code, seq_col;
  logic [1:0]        seq_buf_id;
  logic [23:0]       seq_row;
  logic [SIZE_W-1:0] seq_xfer_size;
  logic [3:0]        chip_sel, rb_sel;
  logic [31:0]       cfg_word;
  logic [2:0]        cfg_ecc_mode;
  logic [6:0]        cfg_ecc_bytes;
  logic [11:0]       cfg_ecc_stat_addr;

  int checks = 0, errors = 0;
  int launch_cnt = 0, busy_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfcr_ctrl_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DLY_W(DLY_W)) u_dut (.*);

  always @(negedge clk) begin
    if (seq_launch) launch_cnt++;
    if (seq_busy)   busy_cycles++;
  end

  // {offset, write data, expected read-back}
  localparam int NVEC = 8;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h04, 32'hFFFF_FFFF, 32'hFF00_0000},   // R2 aux
    {8'h00, 32'hFFFF_FFFE, 32'hFFFF_FF06},   // R2 main, no start
    {8'h08, 32'h1234_ABCD, 32'h0000_ABCD},   // R2 column
    {8'h0C, 32'h84AB_CDEF, 32'h84AB_CDEF},   // R8 row
    {8'h10, 32'hFFFF_FFFF, 32'h0000_1FFF},   // R2 size
    {8'h14, 32'hFFFF_FFFF, 32'h7FFF_00FF},   // R2 config
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},   // R11 unmapped
    {8'h02, 32'hFFFF_FFFF, 32'h0000_0000}    // R11 unaligned
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    while (seq_busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      bus_read(8'(4 * i), rd);
      check("R1 reg reset", rd, 32'h0);
    end
    check("R1 busy/launch/irq", {29'b0, seq_busy, seq_launch, irq}, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][71:64], VEC[i][63:32]);
      bus_read(VEC[i][71:64], rd);
      check("R2/R8/R11 readback", rd, VEC[i][31:0]);
    end

    // R11 unmapped writes left registers untouched
    bus_read(8'h08, rd); check("R11 col kept", rd, 32'h0000_ABCD);
    bus_read(8'h14, rd); check("R11 cfg kept", rd, 32'h7FFF_00FF);
    bus_read(8'h20, rd); check("R11 read high offset", rd, 32'h0);

    // R8 row fields
    check("R8 row", {8'h0, seq_row}, 32'h00AB_CDEF);
    check("R8 chip_sel", {28'h0, chip_sel}, 32'h4);
    check("R8 rb_sel", {28'h0, rb_sel}, 32'h8);

    // R9 / R10 with config all ones: mode 7, field 0x1FF
    check("R9 mode 7", {29'h0, cfg_ecc_mode}, 32'h7);
    check("R9 bytes 60", {25'h0, cfg_ecc_bytes}, 32'd60);
    check("R10 stat addr", {20'h0, cfg_ecc_stat_addr}, 32'hFF8);
    bus_write(8'h14, (32'd6 << 17) | (32'h0FF << 22));
    check("R9 bytes 45", {25'h0, cfg_ecc_bytes}, 32'd45);
    check("R10 stat addr 0x7F8", {20'h0, cfg_ecc_stat_addr}, 32'h7F8);
    bus_write(8'h14, 32'd3 << 17);
    check("R9 mode 3 bytes 0", {25'h0, cfg_ecc_bytes}, 32'd0);
    bus_write(8'h14, 32'h0);
    check("R9 bypass bytes 0", {25'h0, cfg_ecc_bytes}, 32'd0);

    // R12 command fields
    bus_write(8'h04, 32'h3000_0000);
    bus_write(8'h00, 32'h9048_0404);
    bus_write(8'h08, 32'h0000_0800);
    bus_write(8'h10, 32'h0000_0840);
    check("R12 first", {24'h0, seq_cmd_first}, 32'h90);
    check("R12 second", {24'h0, seq_cmd_second}, 32'h30);
    check("R12 code", {16'h0, seq_cycle_code}, 32'h4804);
    check("R12 buf", {30'h0, seq_buf_id}, 32'h2);
    check("R12 col", {16'h0, seq_col}, 32'h0800);
    check("R12 size", {19'h0, seq_xfer_size}, 32'h0840);

    // R3 / R4 launch with delay 5
    seq_delay = 8'd5; launch_cnt = 0; busy_cycles = 0;
    bus_write(8'h00, 32'h707E_E001);
    check("R3 launch pulse", {31'h0, seq_launch}, 32'h1);
    @(negedge clk);
    check("R3 busy after launch", {31'h0, seq_busy}, 32'h1);
    wait_idle();
    check("R4 busy length D=5", busy_cycles, 32'd6);
    check("R3 single launch", launch_cnt, 32'd1);
    bus_read(8'h00, rd); check("R3 start reads 0", rd, 32'h707E_E000);
    bus_read(8'h18, rd); check("R4 idle+done", rd, 32'h6000_0000);
    check("R7 irq off without enable", {31'h0, irq}, 32'h0);

    // R7 / R6 enable and write-one clears
    bus_write(8'h18, 32'h0010_0000);
    check("R7 irq on", {31'h0, irq}, 32'h1);
    bus_read(8'h18, rd); check("R6 enable reads", rd, 32'h6010_0000);
    bus_write(8'h18, 32'h0014_0000);
    bus_read(8'h18, rd); check("R6 clear done", rd, 32'h2010_0000);
    bus_write(8'h18, 32'h0010_0000);
    bus_read(8'h18, rd); check("R6 zero keeps idle", rd, 32'h2010_0000);
    bus_write(8'h18, 32'h0012_0000);
    bus_read(8'h18, rd); check("R6 clear idle", rd, 32'h0010_0000);
    check("R7 irq off after clear", {31'h0, irq}, 32'h0);

    // R4 zero delay
    seq_delay = 8'd0; launch_cnt = 0; busy_cycles = 0;
    bus_write(8'h00, 32'h0000_0001);
    @(negedge clk);
    wait_idle();
    check("R4 busy length D=0", busy_cycles, 32'd1);
    check("R7 irq after finish", {31'h0, irq}, 32'h1);

    // R5 start while busy
    seq_delay = 8'd10; launch_cnt = 0; busy_cycles = 0;
    bus_write(8'h00, 32'h0000_0001);
    repeat (3) @(negedge clk);
    bus_write(8'h00, 32'h0000_0001);
    check("R5 no second launch", {31'h0, seq_launch}, 32'h0);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R5 launch count", launch_cnt, 32'd1);
    check("R5 busy length unchanged", busy_cycles, 32'd11);

    summary();
    $finish;
  end
endmodule